// File: doc/BRIEF.md
# Write-Enable Latch, Status Register and Block Protection Unit

This unit sits beside the command decoder and the page-write sequencer of a serial nonvolatile memory. It keeps the write-enable latch and a two-bit protection level, and it builds the status byte that the read-status command returns. It acts on three decoded command strobes: set-enable, clear-enable and write-status. A set-enable strobe takes effect only while the active-low write-protect pin is high. A clear-enable strobe always takes effect. A write-status strobe is accepted only if the latch is set and the pin is high. When accepted, it requests one timed write cycle from the sequencer.

The new protection level is held pending and copied into the level register when the sequencer reports that the write cycle has completed. Any completed write cycle also clears the latch. While the sequencer reports busy, the status byte reads as all ones and the unit ignores every command strobe.

For any target write address, the unit gives a combinational verdict. The verdict marks the address as locked when its 8-byte page falls inside the protected upper part of the array. That part is none, the top quarter, the top half or the whole array, and its bounds scale with the array-size parameter (128, 256 or 512 bytes).

Top module: `nv_guard`

## Requirements
- R1: After reset the latch is clear, the protection level is 0 and, when not busy, the status byte reads 0x00.
- R2: When not busy, the status byte is {4'b0000, level[1], level[0], latch, 1'b0}. Bits 3 and 2 hold the level, bit 1 holds the latch and bit 0 is the ready flag, which reads 0. While busy, all eight bits read 1.
- R3: A set-enable strobe sets the latch one clock later only if write-protect is high. With write-protect low, the strobe leaves the latch unchanged.
- R4: A clear-enable strobe clears the latch one clock later whatever the level of write-protect.
- R5: A write-complete pulse clears the latch one clock later.
- R6: Level 0 locks no address. Level 1 locks addresses at or above 3/4 of the array size (0x180 for 512 bytes, 0x60 for 128). Level 2 locks addresses at or above half the array size (0x100 for 512, 0x40 for 128). Level 3 locks every address.
- R7: A write-status strobe is accepted only when the latch is set, write-protect is high and the unit is not busy. On acceptance, wrsr_go pulses for one clock in the next cycle. The new level is taken from bits 3:2 of the strobe's data byte, and all other data bits are ignored.
- R8: While busy, the set-enable, clear-enable and write-status strobes have no effect.
- R9: The level changes only in the clock after a write-complete pulse that ends an accepted status write. A completion that ends an array write leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_wren | input | 1 | Set-enable command strobe |
| op_wrdi | input | 1 | Clear-enable command strobe |
| op_wrsr | input | 1 | Write-status command strobe |
| wrsr_byte | input | 8 | Data byte of the write-status command |
| wprot_n | input | 1 | Write-protect pin, low inhibits writes |
| wr_busy | input | 1 | Sequencer write cycle in progress |
| wr_done | input | 1 | One-clock pulse when a write cycle ends |
| wr_addr | input | ADDR_W | Target write address |
| status_byte | output | 8 | Byte returned by the read-status command |
| wen | output | 1 | Write-enable latch state |
| addr_locked | output | 1 | Target address lies in the protected range |
| wrsr_go | output | 1 | Accepted status write, starts a timed cycle |

## Verification
The bench aims at the asymmetric write-protect rule. A design that gated clear-enable with the pin would leave writes enabled after a protected clear-enable. A design that let set-enable through would arm writes under protection. The bench also checks that an array-write completion leaves the level alone, since a design that committed stale pending bits there would change the protection silently. The verdict is swept over every address at every level for both a 512-byte and a 128-byte instance, which catches off-by-one boundaries and fractions that fail to scale. Strobes given while busy are followed by an idle status read, which exposes a latch or level that moved during a write cycle.

// File: rtl/nv_guard_pkg.sv
// Package: shared encodings for the write-guard unit.
// Assumes an 8-bit status byte; positions are fixed by the read-status format.
package nv_guard_pkg;
    localparam int STATUS_W    = 8;
    localparam int ST_READY    = 0;
    localparam int ST_WEN      = 1;
    localparam int ST_LVL_LO   = 2;
    localparam int ST_LVL_HI   = 3;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_QTR  = 2'd1,
        LVL_HALF = 2'd2,
        LVL_ALL  = 2'd3
    } prot_lvl_e;
endpackage

// File: rtl/nv_wel.sv
// Module: write-enable latch.
// Assumes the strobes arrive already qualified by the top (busy, pin).
// Priority: cycle completion, then clear, then set.
module nv_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ok,
    input  logic clr_ok,
    input  logic cycle_done,
    output logic wen_q
);
    // Latch update with completion taking precedence over commands.
    always_ff @(posedge clk) begin
        if (!rst_n)          wen_q <= 1'b0;
        else if (cycle_done) wen_q <= 1'b0;
        else if (clr_ok)     wen_q <= 1'b0;
        else if (set_ok)     wen_q <= 1'b1;
    end
endmodule

// File: rtl/nv_lvl_store.sv
// Module: protection level register with a pending copy.
// Assumes wrsr_ok is already qualified; the pending level is committed
// only when the timed cycle it started reports completion.
module nv_lvl_store
    import nv_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wrsr_ok,
    input  logic [1:0] new_lvl,
    input  logic      cycle_done,
    output prot_lvl_e lvl_q,
    output logic      go_q
);
    logic       pend_q;
    prot_lvl_e  pend_lvl_q;

    // Hold the requested level until its write cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_lvl_q <= LVL_NONE;
        end else if (wrsr_ok) begin
            pend_q     <= 1'b1;
            pend_lvl_q <= prot_lvl_e'(new_lvl);
        end else if (cycle_done) begin
            pend_q     <= 1'b0;
        end
    end

    // Commit the pending level at completion of a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lvl_q <= LVL_NONE;
        else if (cycle_done && pend_q) lvl_q <= pend_lvl_q;
    end

    // One-clock request to the sequencer for an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else        go_q <= wrsr_ok;
    end
endmodule

// File: rtl/nv_prot_map.sv
// Module: address-to-verdict map for the protection level.
// Assumes MEM_BYTES is a power of two and a multiple of 4*PAGE_BYTES,
// so every bound is page aligned and the page base decides the page.
module nv_prot_map
    import nv_guard_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 8,
    parameter int ADDR_W     = $clog2(MEM_BYTES)
) (
    input  prot_lvl_e         lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W:0] QTR_START  = (ADDR_W+1)'(MEM_BYTES - MEM_BYTES/4);
    localparam logic [ADDR_W:0] HALF_START = (ADDR_W+1)'(MEM_BYTES/2);

    logic [ADDR_W-1:0] base;

    generate
        if (PG_W == 0) begin : g_byte_pages
            assign base = addr;
        end else begin : g_multi_pages
            assign base = {addr[ADDR_W-1:PG_W], {PG_W{1'b0}}};
        end
    endgenerate

    // Compare the page base against the bound of the current level.
    always_comb begin
        unique case (lvl)
            LVL_NONE: locked = 1'b0;
            LVL_QTR:  locked = ({1'b0, base} >= QTR_START);
            LVL_HALF: locked = ({1'b0, base} >= HALF_START);
            default:  locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/nv_status_fmt.sv
// Module: status byte assembly.
// Assumes the read-status layout in nv_guard_pkg; busy forces all ones.
module nv_status_fmt
    import nv_guard_pkg::*;
(
    input  logic                busy,
    input  logic                wen,
    input  prot_lvl_e           lvl,
    output logic [STATUS_W-1:0] st
);
    logic [STATUS_W-1:0] idle_st;

    generate
        for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
            if (i == ST_WEN) begin : g_wen
                assign idle_st[i] = wen;
            end else if (i == ST_LVL_LO) begin : g_lo
                assign idle_st[i] = lvl[0];
            end else if (i == ST_LVL_HI) begin : g_hi
                assign idle_st[i] = lvl[1];
            end else begin : g_zero
                assign idle_st[i] = 1'b0;
            end
        end
    endgenerate

    // Select between the idle layout and the all-ones busy pattern.
    always_comb st = busy ? {STATUS_W{1'b1}} : idle_st;
endmodule

// File: rtl/nv_guard.sv
// Module: write-guard top. Qualifies command strobes against busy, the
// write-protect pin and the latch, and ties the latch, level store,
// verdict map and status formatter together.
// Assumes at most one command strobe per clock and wr_done only while busy.
module nv_guard
    import nv_guard_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 8,
    parameter int ADDR_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_wren,
    input  logic              op_wrdi,
    input  logic              op_wrsr,
    input  logic [7:0]        wrsr_byte,
    input  logic              wprot_n,
    input  logic              wr_busy,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        status_byte,
    output logic              wen,
    output logic              addr_locked,
    output logic              wrsr_go
);
    logic      set_ok, clr_ok, wrsr_ok;
    prot_lvl_e bp_lvl;

    // Command qualification: busy blocks all, the pin blocks only writes.
    always_comb begin
        set_ok  = op_wren & ~wr_busy & wprot_n;
        clr_ok  = op_wrdi & ~wr_busy;
        wrsr_ok = op_wrsr & ~wr_busy & wprot_n & wen;
    end

    nv_wel u_wel (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ok     (set_ok),
        .clr_ok     (clr_ok),
        .cycle_done (wr_done),
        .wen_q      (wen)
    );

    nv_lvl_store u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrsr_ok    (wrsr_ok),
        .new_lvl    (wrsr_byte[ST_LVL_HI:ST_LVL_LO]),
        .cycle_done (wr_done),
        .lvl_q      (bp_lvl),
        .go_q       (wrsr_go)
    );

    nv_prot_map #(
        .MEM_BYTES  (MEM_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .ADDR_W     (ADDR_W)
    ) u_map (
        .lvl    (bp_lvl),
        .addr   (wr_addr),
        .locked (addr_locked)
    );

    nv_status_fmt u_fmt (
        .busy (wr_busy),
        .wen  (wen),
        .lvl  (bp_lvl),
        .st   (status_byte)
    );
endmodule

// File: rtl/nv_guard_chk.sv
// Module: property checker for nv_guard, attached by bind below.
module nv_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_wren,
    input logic       op_wrdi,
    input logic       wprot_n,
    input logic       wr_busy,
    input logic       wr_done,
    input logic [7:0] status_byte,
    input logic       wen,
    input logic       addr_locked,
    input logic       wrsr_go,
    input logic [1:0] lvl
);
    p_busy_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> status_byte == 8'hFF);

    p_idle_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_busy |-> (status_byte == {4'b0000, lvl, wen, 1'b0}));

    p_wren_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wren && !wprot_n && !wen && !op_wrdi && !wr_done) |=> !wen);

    p_wrdi_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wrdi && !wr_busy) |=> !wen);

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wen);

    p_all_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'd3) |-> addr_locked);

    p_none_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == 2'd0) |-> !addr_locked);

    p_go_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_go |-> ($past(wen) && $past(wprot_n) && !$past(wr_busy)));

    p_busy_no_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> !wrsr_go);

    p_busy_wen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !wr_done) |=> $stable(wen));

    p_lvl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |=> $stable(lvl));
endmodule

bind nv_guard nv_guard_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_wren     (op_wren),
    .op_wrdi     (op_wrdi),
    .wprot_n     (wprot_n),
    .wr_busy     (wr_busy),
    .wr_done     (wr_done),
    .status_byte (status_byte),
    .wen         (wen),
    .addr_locked (addr_locked),
    .wrsr_go     (wrsr_go),
    .lvl         (bp_lvl)
);

// File: tb/nv_guard_bench.sv
module nv_guard_bench;
    localparam int CLK_P   = 10;
    localparam int BIG     = 512;
    localparam int SMALL   = 128;
    localparam int N_VEC   = 23;

    // Vector fields: [25:22] req, [21:20] op (0 none,1 set,2 clear,3 status write),
    // [19] wprot_n, [18] busy, [17] done, [16:9] data, [8:1] expected status, [0] expected go
    localparam logic [25:0] VEC [N_VEC] = '{
        {4'd1, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R1 idle after reset
        {4'd3, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R3 set blocked by pin
        {4'd3, 2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h02, 1'b0}, // R3 set accepted
        {4'd4, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R4 clear with pin low
        {4'd3, 2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h02, 1'b0}, // R3 set again
        {4'd2, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R2 busy reads ones
        {4'd8, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R8 clear while busy
        {4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h02, 1'b0}, // R8 latch survived
        {4'd7, 2'd3, 1'b0, 1'b0, 1'b0, 8'h0C, 8'h02, 1'b0}, // R7 reject, pin low
        {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 8'h0C, 8'h02, 1'b1}, // R7 accept, go pulse
        {4'd7, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R7 go is one clock
        {4'd5, 2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0}, // R5 completion
        {4'd9, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0C, 1'b0}, // R9 level 3, R5 latch clear
        {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 8'h04, 8'h0C, 1'b0}, // R7 reject, latch clear
        {4'd3, 2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h0E, 1'b0}, // R3 set
        {4'd7, 2'd3, 1'b1, 1'b0, 1'b0, 8'hF7, 8'h0E, 1'b1}, // R7 other data bits ignored
        {4'd5, 2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0}, // R5 completion
        {4'd9, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0}, // R9 level 1 committed
        {4'd3, 2'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h06, 1'b0}, // R3 set
        {4'd5, 2'd0, 1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b0}, // R5 array write ends
        {4'd9, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0}, // R9 level unchanged
        {4'd8, 2'd1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF, 1'b0}, // R8 set while busy
        {4'd8, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h04, 1'b0}  // R8 latch still clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_wren = 1'b0, op_wrdi = 1'b0, op_wrsr = 1'b0;
    logic [7:0] wrsr_byte = 8'h00;
    logic       wprot_n = 1'b1, wr_busy = 1'b0, wr_done = 1'b0;
    logic [8:0] addr_big = '0;
    logic [6:0] addr_small = '0;
    logic [7:0] st_big, st_small;
    logic       wen_big, wen_small, lock_big, lock_small, go_big, go_small;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    nv_guard #(.MEM_BYTES(BIG)) u_nv_guard (
        .clk(clk), .rst_n(rst_n), .op_wren(op_wren), .op_wrdi(op_wrdi),
        .op_wrsr(op_wrsr), .wrsr_byte(wrsr_byte), .wprot_n(wprot_n),
        .wr_busy(wr_busy), .wr_done(wr_done), .wr_addr(addr_big),
        .status_byte(st_big), .wen(wen_big), .addr_locked(lock_big),
        .wrsr_go(go_big)
    );

    nv_guard #(.MEM_BYTES(SMALL)) u_nv_guard_small (
        .clk(clk), .rst_n(rst_n), .op_wren(op_wren), .op_wrdi(op_wrdi),
        .op_wrsr(op_wrsr), .wrsr_byte(wrsr_byte), .wprot_n(wprot_n),
        .wr_busy(wr_busy), .wr_done(wr_done), .wr_addr(addr_small),
        .status_byte(st_small), .wen(wen_small), .addr_locked(lock_small),
        .wrsr_go(go_small)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Drive one command cycle; busy stays held for the sample that follows.
    task automatic step(input logic [1:0] op, input logic wp, input logic busy,
                        input logic done, input logic [7:0] data);
        @(negedge clk);
        op_wren   = (op == 2'd1);
        op_wrdi   = (op == 2'd2);
        op_wrsr   = (op == 2'd3);
        wprot_n   = wp;
        wr_busy   = busy;
        wr_done   = done;
        wrsr_byte = data;
        @(negedge clk);
        op_wren = 1'b0; op_wrdi = 1'b0; op_wrsr = 1'b0; wr_done = 1'b0;
    endtask

    function automatic logic exp_lock(input int lvl, input int a, input int size);
        case (lvl)
            0:       return 1'b0;
            1:       return a >= size - size/4;
            2:       return a >= size/2;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        #(CLK_P * 100000);
        if (!ended) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset status", st_big, 8'h00);
        check("R1", "reset wen", {7'd0, wen_big}, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < N_VEC; i++) begin
            logic [25:0] v;
            v = VEC[i];
            step(v[21:20], v[19], v[18], v[17], v[16:9]);
            check($sformatf("R%0d", v[25:22]), $sformatf("vector %0d status", i), st_big, v[8:1]);
            check($sformatf("R%0d", v[25:22]), $sformatf("vector %0d small status", i), st_small, v[8:1]);
            check($sformatf("R%0d", v[25:22]), $sformatf("vector %0d go", i), {7'd0, go_big}, {7'd0, v[0]});
        end

        // R6: sweep every address at each level for both array sizes
        for (int lvl = 0; lvl < 4; lvl++) begin
            step(2'd1, 1'b1, 1'b0, 1'b0, 8'h00);
            step(2'd3, 1'b1, 1'b0, 1'b0, 8'(lvl << 2));
            step(2'd0, 1'b1, 1'b1, 1'b1, 8'h00);
            step(2'd0, 1'b1, 1'b0, 1'b0, 8'h00);
            check("R6", "level readback", st_big, 8'(lvl << 2));
            for (int a = 0; a < BIG; a++) begin
                addr_big   = 9'(a);
                addr_small = 7'(a % SMALL);
                #1;
                check("R6", $sformatf("lvl %0d addr %03h", lvl, a),
                      {7'd0, lock_big}, {7'd0, exp_lock(lvl, a, BIG)});
                if (a < SMALL)
                    check("R6", $sformatf("small lvl %0d addr %02h", lvl, a),
                          {7'd0, lock_small}, {7'd0, exp_lock(lvl, a, SMALL)});
            end
        end

        // R1: reset mid-run clears latch and level
        step(2'd1, 1'b1, 1'b0, 1'b0, 8'h00);
        check("R3", "set before reset", st_big, 8'h0E);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        addr_big = 9'h1FF;
        #1;
        check("R1", "status after reset", st_big, 8'h00);
        check("R1", "verdict after reset", {7'd0, lock_big}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        ended = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule